// File: doc/BRIEF.md
# Windowed Threshold Fault Detector

This block watches a time-multiplexed stream of signed analogue samples, one sample per clock at most, each tagged with its channel number. Every channel has its own signed acceptance window (a low and a high bound) and its own discrimination time. The discrimination time is the number of that channel's samples in a row that must lie outside the window before the channel is declared faulty. A single sample back inside the window restarts the count. A faulty channel sets a latched bit in a per-channel trip vector.

Beside the analogue windows, a masked set of digital inputs can be declared fault sources, and those trips are latched too. Each analogue channel is assigned to either the fast-abort class or the slow-abort class. Fast-class trips and digital trips are ORed into a fast-abort summary, and that summary drives the switch-open command. An external abort request also drives the open command. The request is mirrored on its own output and does not count as a fault.

All limits, times, enables, classes and the digital mask are loaded through a one-cycle register write port. A clear input drops every latched trip, but only while nothing is currently out of range.

Top module: `win_fault_det`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) zeroes trip_vec, dig_trip, fast_abort, slow_abort, open_cmd and ext_abort, and disables every channel.
- R2: A sample is out of window when, read as signed, it is below the channel's low bound or above its high bound; a sample equal to either bound is in window.
- R3: A sample presented with smp_valid at clock edge k is judged at edge k+1; the channel's trip_vec bit is set at edge k+1 when that sample is the Dth out-of-window sample of that channel in a row, where D is its discrimination time.
- R4: An in-window sample of a channel restarts that channel's run count; samples of other channels do not break the run; a discrimination time of 0 behaves as 1.
- R5: trip_vec and dig_trip bits stay set until a clear is accepted.
- R6: One edge after trip_vec or dig_trip changes, fast_abort is the OR of the trip bits of fast-class channels and all dig_trip bits, and slow_abort is the OR of the trip bits of slow-class channels.
- R7: open_cmd is set at the same edge as fast_abort would be, and also one edge after ext_req is high; ext_abort follows ext_req one edge later; ext_req alone never sets fast_abort.
- R8: A dig_in bit that is high at an edge while its mask bit is set sets the matching dig_trip bit at that edge.
- R9: clr high at an edge clears all trips only when no enabled channel's latest judged sample is out of window, the sample being judged at that edge is not out of window, and no masked dig_in bit is high; otherwise clr has no effect.
- R10: A disabled channel never trips, whatever its samples.
- R11: Configuration: cfg_addr[CHW+1:CHW] selects the word and cfg_addr[CHW-1:0] the channel. Select 0 loads the signed low bound from bits 15:0 and the signed high bound from bits 31:16. Select 1 loads the discrimination time from bits 15:0, the enable from bit 16, and fast class (1) or slow class (0) from bit 17. Select 2 loads the digital mask from bits ND-1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_ch | input | CHW | Channel number of the sample |
| smp_data | input | DW | Signed sample value |
| dig_in | input | ND | Digital input states |
| ext_req | input | 1 | External abort request |
| clr | input | 1 | Request to clear latched trips |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CHW+2 | Word select and channel |
| cfg_wdata | input | 32 | Configuration data |
| trip_vec | output | N_CH | Latched analogue trip per channel |
| dig_trip | output | ND | Latched digital trip per input |
| fast_abort | output | 1 | Fast-abort summary |
| slow_abort | output | 1 | Slow-abort summary |
| open_cmd | output | 1 | Switch-open command |
| ext_abort | output | 1 | External request seen |

## Verification
The assertions take for granted that every sample carries a channel number below N_CH, and that a channel's bounds and discrimination time are not rewritten while one of its samples is in flight. The bench therefore loads all configuration while the sample stream is idle and only uses valid channel numbers. Under those conditions, the trip, summary and stickiness properties relate the latched state to the run and window state and to the clear input. The stimulus covers glitches shorter than the discrimination time, samples exactly on the bounds, a disabled channel, and clears that are refused and accepted for both analogue and digital sources.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
  typedef enum logic [1:0] {
    SEL_LIMIT = 2'd0,
    SEL_MODE  = 2'd1,
    SEL_DMASK = 2'd2
  } cfg_sel_e;

  localparam int CFG_W     = 32;
  localparam int HI_LSB    = 16;
  localparam int EN_BIT    = 16;
  localparam int FAST_BIT  = 17;
endpackage

// File: rtl/wfd_cfg_store.sv
module wfd_cfg_store
  import wfd_pkg::*;
#(
  parameter int N_CH = 32,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int ND   = 16,
  parameter int CHW  = $clog2(N_CH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [CHW+1:0]       addr,
  input  logic [CFG_W-1:0]     wdata,
  input  logic [CHW-1:0]       rd_ch,
  output logic [DW-1:0]        lo_o,
  output logic [DW-1:0]        hi_o,
  output logic [CW-1:0]        dt_o,
  output logic [N_CH-1:0]      en_vec,
  output logic [N_CH-1:0]      fast_vec,
  output logic [ND-1:0]        dmask
);
  localparam bit POW2 = ((1 << CHW) == N_CH);

  logic [2*DW-1:0] lim_mem [N_CH];
  logic [CW-1:0]   dt_mem  [N_CH];
  cfg_sel_e        sel;
  logic [CHW-1:0]  idx;
  logic            idx_ok, rd_ok;
  logic            unused_wbits;

  assign sel    = cfg_sel_e'(addr[CHW+1:CHW]);
  assign idx    = addr[CHW-1:0];
  assign idx_ok = POW2 ? 1'b1 : (int'(idx) < N_CH);
  assign rd_ok  = POW2 ? 1'b1 : (int'(rd_ch) < N_CH);
  assign unused_wbits = ^wdata;

  // block-RAM style storage: write port plus registered read port
  always_ff @(posedge clk) begin
    if (we && idx_ok && sel == SEL_LIMIT)
      lim_mem[idx] <= {wdata[HI_LSB+DW-1:HI_LSB], wdata[DW-1:0]};
    if (we && idx_ok && sel == SEL_MODE)
      dt_mem[idx] <= wdata[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rd_ok) begin
      {hi_o, lo_o} <= lim_mem[rd_ch];
      dt_o         <= dt_mem[rd_ch];
    end
  end

  // per-channel control bits kept in flops so reset leaves them defined
  always_ff @(posedge clk) begin
    if (rst) begin
      en_vec   <= '0;
      fast_vec <= '0;
      dmask    <= '0;
    end else if (we) begin
      if (sel == SEL_MODE && idx_ok) begin
        en_vec[idx]   <= wdata[EN_BIT];
        fast_vec[idx] <= wdata[FAST_BIT];
      end
      if (sel == SEL_DMASK)
        dmask <= wdata[ND-1:0];
    end
  end
endmodule

// File: rtl/wfd_chan_eval.sv
module wfd_chan_eval #(
  parameter int N_CH = 32,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int CHW  = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s1_vld,
  input  logic [CHW-1:0]  s1_ch,
  input  logic [DW-1:0]   s1_data,
  input  logic [DW-1:0]   lo,
  input  logic [DW-1:0]   hi,
  input  logic [CW-1:0]   dt,
  input  logic [N_CH-1:0] en_vec,
  input  logic            clr_go,
  output logic [N_CH-1:0] trip_q,
  output logic            busy
);
  localparam bit          POW2    = ((1 << CHW) == N_CH);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0]   cnt_q [N_CH];
  logic [N_CH-1:0] out_q;
  logic            ch_ok, in_win, out_now, trip_now;
  logic [CW-1:0]   cnt_cur, cnt_nxt, dt_eff;

  assign ch_ok   = POW2 ? 1'b1 : (int'(s1_ch) < N_CH);
  assign in_win  = ($signed(s1_data) >= $signed(lo)) && ($signed(s1_data) <= $signed(hi));
  assign out_now = s1_vld && ch_ok && en_vec[s1_ch] && !in_win;
  assign cnt_cur = cnt_q[s1_ch];

  always_comb begin
    if (!out_now)               cnt_nxt = '0;
    else if (cnt_cur == CNT_MAX) cnt_nxt = CNT_MAX;
    else                        cnt_nxt = cnt_cur + CNT_ONE;
  end

  assign dt_eff   = (dt == '0) ? CNT_ONE : dt;
  assign trip_now = out_now && (cnt_nxt >= dt_eff);
  assign busy     = (|out_q) || out_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_CH; i++) cnt_q[i] <= '0;
      out_q  <= '0;
      trip_q <= '0;
    end else begin
      if (clr_go) trip_q <= '0;
      if (s1_vld && ch_ok) begin
        cnt_q[s1_ch] <= cnt_nxt;
        out_q[s1_ch] <= out_now;
        if (trip_now) trip_q[s1_ch] <= 1'b1;
      end
    end
  end

  // R5: a trip bit only falls on an accepted clear
  assert_trip_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !clr_go |=> ((trip_q & $past(trip_q)) == $past(trip_q)));

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    // R4: a channel whose latest sample was in window holds an empty run
    assert_run_cleared_R4: assert property (@(posedge clk) disable iff (rst)
      !out_q[g] |-> (cnt_q[g] == '0));
    // R3: a trip only appears together with an out-of-window judgement
    assert_trip_needs_out_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(trip_q[g]) |-> out_q[g]);
    // R10: a trip only appears on a channel that was enabled
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(trip_q[g]) |-> $past(en_vec[g]));
  end
endmodule

// File: rtl/wfd_summary.sv
module wfd_summary #(
  parameter int N_CH = 32,
  parameter int ND   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ND-1:0]   dig_in,
  input  logic [ND-1:0]   dmask,
  input  logic [N_CH-1:0] trip_vec,
  input  logic [N_CH-1:0] fast_vec,
  input  logic            ana_busy,
  input  logic            clr,
  input  logic            ext_req,
  output logic            clr_go,
  output logic [ND-1:0]   dig_trip,
  output logic            fast_abort,
  output logic            slow_abort,
  output logic            open_cmd,
  output logic            ext_abort
);
  logic [ND-1:0] dig_now;
  logic          fast_or, slow_or;

  assign dig_now = dig_in & dmask;
  assign clr_go  = clr && !ana_busy && (dig_now == '0);
  assign fast_or = (|(trip_vec & fast_vec)) || (|dig_trip);
  assign slow_or = |(trip_vec & ~fast_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      dig_trip   <= '0;
      fast_abort <= 1'b0;
      slow_abort <= 1'b0;
      open_cmd   <= 1'b0;
      ext_abort  <= 1'b0;
    end else begin
      dig_trip   <= clr_go ? '0 : (dig_trip | dig_now);
      fast_abort <= fast_or;
      slow_abort <= slow_or;
      open_cmd   <= fast_or || ext_req;
      ext_abort  <= ext_req;
    end
  end

  // R9: latched digital trips only drop after a clear request
  assert_dig_clear_needs_clr_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(|dig_trip) |-> $past(clr));
  // R7: an external request always reaches the open command
  assert_ext_opens_R7: assert property (@(posedge clk) disable iff (rst)
    ext_req |=> (open_cmd && ext_abort));
  // R6: a latched digital trip always raises the fast summary
  assert_dig_fast_R6: assert property (@(posedge clk) disable iff (rst)
    (|dig_trip) |=> fast_abort);
endmodule

// File: rtl/win_fault_det.sv
module win_fault_det #(
  parameter int N_CH = 32,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int ND   = 16,
  localparam int CHW = $clog2(N_CH),
  localparam int AW  = CHW + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_valid,
  input  logic [CHW-1:0]  smp_ch,
  input  logic [DW-1:0]   smp_data,
  input  logic [ND-1:0]   dig_in,
  input  logic            ext_req,
  input  logic            clr,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [N_CH-1:0] trip_vec,
  output logic [ND-1:0]   dig_trip,
  output logic            fast_abort,
  output logic            slow_abort,
  output logic            open_cmd,
  output logic            ext_abort
);
  logic            s1_vld;
  logic [CHW-1:0]  s1_ch;
  logic [DW-1:0]   s1_data;
  logic [DW-1:0]   lo, hi;
  logic [CW-1:0]   dt;
  logic [N_CH-1:0] en_vec, fast_vec;
  logic [ND-1:0]   dmask;
  logic            clr_go, ana_busy;

  // stage 1: sample registered alongside the configuration read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_ch   <= '0;
      s1_data <= '0;
    end else begin
      s1_vld  <= smp_valid;
      s1_ch   <= smp_ch;
      s1_data <= smp_data;
    end
  end

  wfd_cfg_store #(.N_CH(N_CH), .DW(DW), .CW(CW), .ND(ND), .CHW(CHW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rd_ch(smp_ch), .lo_o(lo), .hi_o(hi), .dt_o(dt),
    .en_vec(en_vec), .fast_vec(fast_vec), .dmask(dmask)
  );

  wfd_chan_eval #(.N_CH(N_CH), .DW(DW), .CW(CW), .CHW(CHW)) u_eval (
    .clk(clk), .rst(rst), .s1_vld(s1_vld), .s1_ch(s1_ch), .s1_data(s1_data),
    .lo(lo), .hi(hi), .dt(dt), .en_vec(en_vec), .clr_go(clr_go),
    .trip_q(trip_vec), .busy(ana_busy)
  );

  wfd_summary #(.N_CH(N_CH), .ND(ND)) u_sum (
    .clk(clk), .rst(rst), .dig_in(dig_in), .dmask(dmask), .trip_vec(trip_vec),
    .fast_vec(fast_vec), .ana_busy(ana_busy), .clr(clr), .ext_req(ext_req),
    .clr_go(clr_go), .dig_trip(dig_trip), .fast_abort(fast_abort),
    .slow_abort(slow_abort), .open_cmd(open_cmd), .ext_abort(ext_abort)
  );

  // R3: samples must name an existing channel
  assert_sample_channel_R3: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> (int'(smp_ch) < N_CH));
  // R1: all summaries are quiet on the first edge after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!fast_abort && !slow_abort && !open_cmd && trip_vec == '0));
endmodule

// File: tb/win_fault_det_bench.sv
`timescale 1ns/1ps
module win_fault_det_bench;
  localparam int N_CH = 32;
  localparam int ND   = 16;
  localparam int CHW  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [CHW-1:0] smp_ch = '0;
  logic [15:0] smp_data = '0;
  logic [ND-1:0] dig_in = '0;
  logic ext_req = 1'b0, clr = 1'b0, cfg_we = 1'b0;
  logic [CHW+1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [N_CH-1:0] trip_vec;
  logic [ND-1:0] dig_trip;
  logic fast_abort, slow_abort, open_cmd, ext_abort;

  always #5 clk = ~clk;

  win_fault_det u_win_fault_det (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ch(smp_ch), .smp_data(smp_data),
    .dig_in(dig_in), .ext_req(ext_req), .clr(clr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trip_vec(trip_vec), .dig_trip(dig_trip), .fast_abort(fast_abort),
    .slow_abort(slow_abort), .open_cmd(open_cmd), .ext_abort(ext_abort)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int m_lo [N_CH], m_hi [N_CH], m_dt [N_CH], m_cnt [N_CH];
  logic [N_CH-1:0] m_en = '0, m_fast = '0, m_outf = '0, m_trip = '0;
  logic [ND-1:0] m_mask = '0, m_dtrip = '0;
  bit m_fa = 0, m_sa = 0, m_oc = 0, m_ea = 0;
  bit m_pv = 0; int m_pch = 0; int m_pd = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [ND-1:0] dm;
    bit p_out, quiet, cg, fc, sc;
    int dte;
    if (rst) begin
      for (int i = 0; i < N_CH; i++) m_cnt[i] = 0;
      m_en = '0; m_fast = '0; m_outf = '0; m_trip = '0; m_mask = '0; m_dtrip = '0;
      m_fa = 0; m_sa = 0; m_oc = 0; m_ea = 0; m_pv = 0;
    end else begin
      dm = dig_in & m_mask;
      p_out = m_pv && m_en[m_pch] && (m_pd < m_lo[m_pch] || m_pd > m_hi[m_pch]);
      quiet = (m_outf == '0) && !p_out && (dm == '0);
      cg = clr && quiet;
      fc = (m_dtrip != '0); sc = 0;
      for (int i = 0; i < N_CH; i++)
        if (m_trip[i]) begin if (m_fast[i]) fc = 1; else sc = 1; end
      m_fa = fc; m_sa = sc; m_oc = fc || ext_req; m_ea = ext_req;
      m_dtrip = cg ? '0 : (m_dtrip | dm);
      if (cg) m_trip = '0;
      if (m_pv) begin
        if (p_out) begin if (m_cnt[m_pch] < 65535) m_cnt[m_pch]++; end
        else m_cnt[m_pch] = 0;
        m_outf[m_pch] = p_out;
        dte = (m_dt[m_pch] == 0) ? 1 : m_dt[m_pch];
        if (p_out && m_cnt[m_pch] >= dte) m_trip[m_pch] = 1'b1;
      end
      if (cfg_we) begin
        case (cfg_addr[CHW+1:CHW])
          2'd0: begin
            m_lo[cfg_addr[CHW-1:0]] = int'($signed(cfg_wdata[15:0]));
            m_hi[cfg_addr[CHW-1:0]] = int'($signed(cfg_wdata[31:16]));
          end
          2'd1: begin
            m_dt[cfg_addr[CHW-1:0]]   = int'(cfg_wdata[15:0]);
            m_en[cfg_addr[CHW-1:0]]   = cfg_wdata[16];
            m_fast[cfg_addr[CHW-1:0]] = cfg_wdata[17];
          end
          2'd2: m_mask = cfg_wdata[ND-1:0];
          default: ;
        endcase
      end
      m_pv = smp_valid; m_pch = int'(smp_ch); m_pd = int'($signed(smp_data));
    end
  endtask

  task automatic compare_all();
    check(trip_vec == m_trip, "R3 trip_vec", trip_vec, m_trip);
    check(dig_trip == m_dtrip, "R8 dig_trip", dig_trip, m_dtrip);
    check(fast_abort == m_fa, "R6 fast_abort", fast_abort, m_fa);
    check(slow_abort == m_sa, "R6 slow_abort", slow_abort, m_sa);
    check(open_cmd == m_oc, "R7 open_cmd", open_cmd, m_oc);
    check(ext_abort == m_ea, "R7 ext_abort", ext_abort, m_ea);
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic sample(int ch, int val);
    smp_valid = 1'b1; smp_ch = CHW'(ch); smp_data = 16'(val);
    step();
    smp_valid = 1'b0;
  endtask

  task automatic cfg_write(int sel, int ch, logic [31:0] data);
    cfg_we = 1'b1; cfg_addr = {2'(sel), CHW'(ch)}; cfg_wdata = data;
    step();
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mode_word(int dt, bit en, bit fast);
    return {14'd0, fast, en, 16'(dt)};
  endfunction

  task automatic in_all();
    for (int c = 0; c < N_CH; c++) sample(c, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    check(trip_vec == '0 && dig_trip == '0, "R1 trips after reset", {trip_vec, dig_trip}, 0);
    check(!fast_abort && !slow_abort && !open_cmd && !ext_abort, "R1 summaries after reset",
          {fast_abort, slow_abort, open_cmd, ext_abort}, 0);
    rst = 1'b0;
    idle(1);

    // R11: load windows -100..100, times, even channels fast
    for (int c = 0; c < N_CH; c++) begin
      cfg_write(0, c, {16'(100), 16'(-100)});
      cfg_write(1, c, mode_word((c == 2) ? 5 : c % 4, 1'b1, (c % 2) == 0));
    end
    idle(2);

    // R2: stream in window, including values on both bounds
    for (int c = 0; c < N_CH; c++) sample(c, (c % 3 == 0) ? -100 : ((c % 3 == 1) ? 100 : c));
    idle(3);
    check(trip_vec == '0, "R2 bound values stay in window", trip_vec, 0);

    // R4: ch2 (time 5) four out samples then one in, interleaved with others
    for (int k = 0; k < 4; k++) begin sample(2, 101); sample(9, 5); end
    sample(2, 50); idle(3);
    check(trip_vec[2] == 1'b0, "R4 short run on ch2 no trip", trip_vec[2], 0);

    // R3: five consecutive out samples of ch2, other channels between
    for (int k = 0; k < 5; k++) begin sample(2, -101); sample(4, 0); end
    idle(3);
    check(trip_vec[2] == 1'b1, "R3 ch2 trips after five", trip_vec[2], 1);
    check(fast_abort && open_cmd, "R6 fast class summary", {fast_abort, open_cmd}, 3);

    // R4: time 0 behaves as 1 on ch0
    sample(0, 101); idle(3);
    check(trip_vec[0] == 1'b1, "R4 zero time trips on one", trip_vec[0], 1);

    // R10: disable ch5, then drive it far out
    cfg_write(1, 5, mode_word(1, 1'b0, 1'b0)); idle(1);
    for (int k = 0; k < 4; k++) sample(5, -30000);
    idle(3);
    check(trip_vec[5] == 1'b0, "R10 disabled ch5 no trip", trip_vec[5], 0);

    // R6: slow channel ch1
    check(slow_abort == 1'b0, "R6 slow idle", slow_abort, 0);
    sample(1, 32767); idle(3);
    check(slow_abort == 1'b1, "R6 slow class summary", slow_abort, 1);

    // R5: back in window, trips remain
    in_all(); idle(3);
    check(trip_vec[2:0] == 3'b111, "R5 trips latched", trip_vec[2:0], 7);

    // R9: clear refused while ch3 out
    for (int k = 0; k < 2; k++) sample(3, 200);
    clr = 1'b1; step(); clr = 1'b0; idle(2);
    check(trip_vec[2:0] == 3'b111, "R9 clear refused while out", trip_vec[2:0], 7);
    in_all(); idle(2);
    clr = 1'b1; step(); clr = 1'b0; idle(3);
    check(trip_vec == '0 && !fast_abort && !slow_abort, "R9 clear accepted", trip_vec, 0);

    // R8: digital mask
    cfg_write(2, 0, 32'h0000_00F0); idle(1);
    dig_in = 16'h0100; idle(3);
    check(dig_trip == '0, "R8 unmasked input ignored", dig_trip, 0);
    dig_in = 16'h0010; idle(1);
    check(dig_trip == 16'h0010, "R8 masked input latches", dig_trip, 16'h10);
    clr = 1'b1; step(); clr = 1'b0; idle(1);
    check(dig_trip == 16'h0010, "R9 clear refused while digital active", dig_trip, 16'h10);
    dig_in = '0; idle(2);
    check(fast_abort == 1'b1, "R5 digital trip latched", fast_abort, 1);
    clr = 1'b1; step(); clr = 1'b0; idle(3);
    check(dig_trip == '0 && !fast_abort, "R9 digital clear accepted", dig_trip, 0);

    // R7: external request
    ext_req = 1'b1; step(); ext_req = 1'b0;
    check(open_cmd && ext_abort && !fast_abort, "R7 external request",
          {open_cmd, ext_abort, fast_abort}, 6);
    idle(2);

    // R11: narrow window on ch7 (time 3), value below low bound
    cfg_write(0, 7, {16'(20), 16'(10)}); idle(1);
    sample(7, 10); sample(7, 20); idle(2);
    check(trip_vec[7] == 1'b0, "R11 new bounds inclusive", trip_vec[7], 0);
    for (int k = 0; k < 3; k++) sample(7, 5);
    idle(3);
    check(trip_vec[7] == 1'b1 && slow_abort, "R11 new window trips", trip_vec[7], 1);

    // back-to-back samples of one channel, then reset
    in_all();
    for (int k = 0; k < 3; k++) sample(3, -500);
    idle(3);
    check(trip_vec[3] == 1'b1, "R3 back-to-back samples trip", trip_vec[3], 1);
    rst = 1'b1; idle(2);
    check(trip_vec == '0 && !open_cmd, "R1 reset clears trips", trip_vec, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule